// File: doc/BRIEF.md
# Byte-Wide Page-Mode DRAM Controller

This block joins a 16-bit processor bus to a DRAM array whose data path is a single byte wide. Every word access becomes one row cycle holding two column strobes. The two columns differ only in their lowest bit. Read bytes are gathered into a latch, and the full word is returned in one go. Write words are copied into a latch and then split into two bytes. Every strobe edge sits on a clock edge, so no delay lines are needed. The address or data that a strobe qualifies is valid for a whole clock before that edge and a whole clock after it.

On the processor side, a request is held until a one-cycle acknowledge arrives. The processor waits in wait states until the acknowledge comes. The processor must drop its request in the cycle after the acknowledge.

Three features hide the cost of the narrow memory:
- A single-entry posted-write buffer acknowledges a write as soon as it is latched. The buffer then drains in the background.
- A one-word prefetch buffer fetches the next sequential word after every read. The word address wraps from the top of memory to zero. A following read of that word is answered from the buffer without a row cycle.
- A timer requests a CAS-before-RAS refresh at a fixed interval. Refresh runs between row cycles.

The strobe sequencer has these states:
- IDLE
- ROW: row address set up
- RAS: row strobe low, row address held
- COL0, CAS0, CH0: setup, strobe and hold for the even column
- COL1, CAS1, CH1: the same three states for the odd column
- PRE: precharge
- RF0, RF1, RF2: refresh

Its transitions are:
- IDLE→RF0 when refresh is pending.
- IDLE→ROW when an access is launched.
- ROW→RAS→COL0→CAS0→CH0→COL1→CAS1→CH1→PRE, one clock per step.
- RF0→RF1→RF2→PRE.
- PRE→IDLE after the precharge count expires.

In IDLE, work is chosen in this order: refresh, then draining the posted write, then a processor read miss, then the pending prefetch.

Top module: `pagemode_dram_ctrl`

## Requirements
- R1: While reset is held and right after it, all three DRAM strobes are high, the DRAM data driver is off, and the acknowledge is low.
- R2: A read of word A that misses the prefetch buffer costs one row cycle. The row is A[6:3] and the columns are {A[2:0],0} then {A[2:0],1}. The returned word is {odd-column byte, even-column byte}. The acknowledge is a one-cycle pulse that comes more than two clocks after the request.
- R3: When a row strobe falls outside refresh, the row address is on the address pins in the clock before the fall and in the clock after it.
- R4: Around every column strobe fall inside a row cycle, the column address is unchanged for the clock before and the clock after. During writes, the driven data byte is also unchanged over the same two clocks.
- R5: A write of word D to A stores D[7:0] at column {A[2:0],0} and D[15:8] at column {A[2:0],1}, with the write-enable low.
- R6: A write arriving while the posted buffer is empty is acknowledged within two clocks. A second write arriving while the first is still draining waits for the drain to finish.
- R7: After a read of A, a read of A+1 (modulo the word count) returns the correct word within two clocks and starts no row cycle.
- R8: A write to the prefetched address invalidates the prefetch buffer, so a later read of that address returns the written word.
- R9: A read of an address with a posted write still pending returns the posted word.
- R10: A refresh is requested every REF_PERIOD clocks. Refresh runs with the column strobe falling before the row strobe and the write-enable high. In IDLE, a pending refresh starts before any access or prefetch.
- R11: The row strobe stays high for at least TRP clocks between any two row-strobe assertions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ROW_W+COL_W-1 | Word address |
| cpu_wdata | input | 16 | Write word |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read word, valid with cpu_ack |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 8 | Byte driven toward the DRAM |
| dram_dq_oe | output | 1 | Enable for the byte driver |
| dram_dq_in | input | 8 | Byte returned by the DRAM |

## Verification
Reads are applied in three patterns:
- Isolated misses at addresses in different rows. These separate the byte order and the row/column split.
- Sequential pairs, including the wrap from the top word to zero. These show whether the second word comes from the prefetch buffer, since a hit starts no row cycle.
- Reads that follow a write to the same address, either while the write is still posted or after it has overwritten a prefetched word. These separate correct ordering and invalidation from stale data.

Writes are applied alone and back to back. Back-to-back writes show whether the single-entry buffer stalls the second write. A mid-cycle monitor of the DRAM pins tracks refresh and pin timing over the whole run:
- refresh cycles, and the write-enable level seen during each
- address and data stability around each strobe fall
- precharge gaps between row cycles

// File: rtl/drc_pkg.sv
package drc_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ROW, ST_RAS,
        ST_COL0, ST_CAS0, ST_CH0,
        ST_COL1, ST_CAS1, ST_CH1,
        ST_PRE, ST_RF0, ST_RF1, ST_RF2
    } drc_state_e;

    typedef enum logic [1:0] {
        OP_RD_CPU, OP_RD_PF, OP_WR
    } drc_op_e;
endpackage

// File: rtl/drc_refresh_tmr.sv
module drc_refresh_tmr #(
    parameter int PERIOD = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic pend_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_o <= 1'b0;
        end else begin
            if (cnt_q == CW'(PERIOD - 1)) begin
                cnt_q  <= '0;
                pend_o <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (clr_i) pend_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/drc_seq.sv
module drc_seq import drc_pkg::*; #(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int TRP   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_go_i,
    input  logic                   ref_go_i,
    input  logic                   wr_i,
    input  logic [ROW_W-1:0]       row_i,
    input  logic [COL_W-2:0]       colw_i,
    input  logic [15:0]            wdat_i,
    input  logic [7:0]             dq_in_i,
    output logic                   idle_o,
    output logic                   done_o,
    output logic [15:0]            rdat_o,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr_o,
    output logic                   ras_n_o,
    output logic                   cas_n_o,
    output logic                   we_n_o,
    output logic                   dq_oe_o,
    output logic [7:0]             dq_out_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int MA  = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int PCW = $clog2(TRP + 1);

    drc_state_e       state_q, state_d;
    logic [PCW-1:0]   prc_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-2:0] colw_q;
    logic [15:0]      wd_q;
    logic             wr_q;
    logic [7:0]       b0_q, b1_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_go_i)      state_d = ST_RF0;
                else if (acc_go_i) state_d = ST_ROW;
            end
            ST_ROW:  state_d = ST_RAS;
            ST_RAS:  state_d = ST_COL0;
            ST_COL0: state_d = ST_CAS0;
            ST_CAS0: state_d = ST_CH0;
            ST_CH0:  state_d = ST_COL1;
            ST_COL1: state_d = ST_CAS1;
            ST_CAS1: state_d = ST_CH1;
            ST_CH1:  state_d = ST_PRE;
            ST_PRE:  if (prc_q == PCW'(TRP - 1)) state_d = ST_IDLE;
            ST_RF0:  state_d = ST_RF1;
            ST_RF1:  state_d = ST_RF2;
            ST_RF2:  state_d = ST_PRE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath: precharge count, access latches, read byte latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prc_q  <= '0;
            row_q  <= '0;
            colw_q <= '0;
            wd_q   <= '0;
            wr_q   <= 1'b0;
            b0_q   <= '0;
            b1_q   <= '0;
        end else begin
            prc_q <= (state_q == ST_PRE) ? prc_q + 1'b1 : '0;
            if (state_q == ST_IDLE && acc_go_i && !ref_go_i) begin
                row_q  <= row_i;
                colw_q <= colw_i;
                wd_q   <= wdat_i;
                wr_q   <= wr_i;
            end
            if (state_q == ST_CAS0 && !wr_q) b0_q <= dq_in_i;
            if (state_q == ST_CAS1 && !wr_q) b1_q <= dq_in_i;
        end
    end

    // outputs
    always_comb begin
        ras_n_o  = 1'b1;
        cas_n_o  = 1'b1;
        we_n_o   = 1'b1;
        dq_oe_o  = 1'b0;
        addr_o   = '0;
        dq_out_o = wd_q[7:0];
        unique case (state_q)
            ST_IDLE, ST_PRE: ;
            ST_ROW: addr_o = MA'(row_q);
            ST_RAS: begin
                ras_n_o = 1'b0;
                addr_o  = MA'(row_q);
            end
            ST_COL0, ST_CAS0, ST_CH0: begin
                ras_n_o = 1'b0;
                cas_n_o = (state_q != ST_CAS0);
                addr_o  = MA'({colw_q, 1'b0});
                we_n_o  = !wr_q;
                dq_oe_o = wr_q;
            end
            ST_COL1, ST_CAS1, ST_CH1: begin
                ras_n_o  = 1'b0;
                cas_n_o  = (state_q != ST_CAS1);
                addr_o   = MA'({colw_q, 1'b1});
                we_n_o   = !wr_q;
                dq_oe_o  = wr_q;
                dq_out_o = wd_q[15:8];
            end
            ST_RF0: cas_n_o = 1'b0;
            ST_RF1: begin
                cas_n_o = 1'b0;
                ras_n_o = 1'b0;
            end
            ST_RF2: ras_n_o = 1'b0;
            default: ;
        endcase
    end

    assign idle_o = (state_q == ST_IDLE);
    assign done_o = (state_q == ST_CH1);
    assign rdat_o = {b1_q, b0_q};

    // R3
    row_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) && cas_n_o) |-> $stable(addr_o));
    // R4
    col_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n_o) && !ras_n_o) |-> $stable(addr_o));
    // R4
    col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n_o) && !ras_n_o) |=> $stable(addr_o));
    // R4
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n_o) && !ras_n_o && dq_oe_o) |=> $stable(dq_out_o));
    // R10
    cbr_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) && !cas_n_o) |-> we_n_o);
endmodule

// File: rtl/pagemode_dram_ctrl.sv
module pagemode_dram_ctrl import drc_pkg::*; #(
    parameter int ROW_W      = 4,
    parameter int COL_W      = 4,
    parameter int TRP        = 2,
    parameter int REF_PERIOD = 250
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req,
    input  logic                         cpu_we,
    input  logic [ROW_W+COL_W-2:0]       cpu_addr,
    input  logic [15:0]                  cpu_wdata,
    output logic                         cpu_ack,
    output logic [15:0]                  cpu_rdata,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic                         dram_ras_n,
    output logic                         dram_cas_n,
    output logic                         dram_we_n,
    output logic [7:0]                   dram_dq_out,
    output logic                         dram_dq_oe,
    input  logic [7:0]                   dram_dq_in
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW  = ROW_W + COL_W - 1;
    localparam int RCW = $clog2(TRP + 2) + 1;

    logic          rf_pend, seq_idle, seq_done;
    logic [15:0]   seq_rdat;
    logic          pw_valid, pf_valid, pf_want, ack_q;
    logic [AW-1:0] pw_addr, pf_addr, pf_next, op_addr, sel_addr;
    logic [15:0]   pw_data, pf_data;
    drc_op_e       op_kind, sel_kind;
    logic          hit, wr_acc, miss, acc_go, ref_go;

    assign hit    = cpu_req && !cpu_we && !ack_q && pf_valid && (pf_addr == cpu_addr);
    assign wr_acc = cpu_req && cpu_we && !ack_q && !pw_valid;
    assign miss   = cpu_req && !cpu_we && !ack_q && !hit;
    assign ref_go = seq_idle && rf_pend;
    assign acc_go = seq_idle && !rf_pend && (pw_valid || miss || pf_want);

    always_comb begin
        if (pw_valid) begin
            sel_kind = OP_WR;
            sel_addr = pw_addr;
        end else if (miss) begin
            sel_kind = OP_RD_CPU;
            sel_addr = cpu_addr;
        end else begin
            sel_kind = OP_RD_PF;
            sel_addr = pf_next;
        end
    end

    drc_refresh_tmr #(.PERIOD(REF_PERIOD)) i_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ref_go),
        .pend_o (rf_pend)
    );

    drc_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .TRP(TRP)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_go_i (acc_go),
        .ref_go_i (ref_go),
        .wr_i     (sel_kind == OP_WR),
        .row_i    (sel_addr[AW-1:COL_W-1]),
        .colw_i   (sel_addr[COL_W-2:0]),
        .wdat_i   (pw_data),
        .dq_in_i  (dram_dq_in),
        .idle_o   (seq_idle),
        .done_o   (seq_done),
        .rdat_o   (seq_rdat),
        .addr_o   (dram_addr),
        .ras_n_o  (dram_ras_n),
        .cas_n_o  (dram_cas_n),
        .we_n_o   (dram_we_n),
        .dq_oe_o  (dram_dq_oe),
        .dq_out_o (dram_dq_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_valid  <= 1'b0;
            pf_valid  <= 1'b0;
            pf_want   <= 1'b0;
            ack_q     <= 1'b0;
            pw_addr   <= '0;
            pw_data   <= '0;
            pf_addr   <= '0;
            pf_data   <= '0;
            pf_next   <= '0;
            op_addr   <= '0;
            op_kind   <= OP_RD_CPU;
            cpu_rdata <= '0;
        end else begin
            ack_q <= 1'b0;
            if (acc_go) begin
                op_addr <= sel_addr;
                op_kind <= sel_kind;
                if (sel_kind == OP_RD_PF) pf_want <= 1'b0;
            end
            if (seq_done) begin
                unique case (op_kind)
                    OP_WR: pw_valid <= 1'b0;
                    OP_RD_CPU: begin
                        cpu_rdata <= seq_rdat;
                        ack_q     <= 1'b1;
                        pf_want   <= 1'b1;
                        pf_next   <= op_addr + 1'b1;
                    end
                    OP_RD_PF: begin
                        if (!(pw_valid && pw_addr == op_addr) &&
                            !(wr_acc && cpu_addr == op_addr)) begin
                            pf_valid <= 1'b1;
                            pf_addr  <= op_addr;
                            pf_data  <= seq_rdat;
                        end
                    end
                    default: ;
                endcase
            end
            if (hit) begin
                cpu_rdata <= pf_data;
                ack_q     <= 1'b1;
                pf_want   <= 1'b1;
                pf_next   <= cpu_addr + 1'b1;
            end
            if (wr_acc) begin
                pw_valid <= 1'b1;
                pw_addr  <= cpu_addr;
                pw_data  <= cpu_wdata;
                ack_q    <= 1'b1;
                if (pf_valid && pf_addr == cpu_addr) pf_valid <= 1'b0;
            end
        end
    end

    assign cpu_ack = ack_q;

    // precharge watcher: consecutive clocks with the row strobe high
    logic [RCW-1:0] ras_hi_q;
    always_ff @(posedge clk) begin
        if (!rst_n)          ras_hi_q <= RCW'(TRP + 1);
        else if (!dram_ras_n) ras_hi_q <= '0;
        else if (ras_hi_q < RCW'(TRP + 1)) ras_hi_q <= ras_hi_q + 1'b1;
    end

    // R11
    precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (ras_hi_q >= RCW'(TRP)));
    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);
    // R10
    refresh_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && rf_pend) |=> (!dram_cas_n && dram_ras_n));
endmodule

// File: tb/test_pagemode_dram_ctrl.sv
module test_pagemode_dram_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int ROW_W = 4, COL_W = 4, TRP = 2, REF = 250;
    localparam int AW = ROW_W + COL_W - 1;
    localparam int MA = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0, cpu_rdata;
    logic cpu_ack;
    logic [MA-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    logic [7:0] dram_dq_out, dram_dq_in;

    pagemode_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .TRP(TRP), .REF_PERIOD(REF))
    i_pagemode_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
        .cpu_rdata(cpu_rdata), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int rowcyc = 0, cbr = 0, cbr_bad = 0, r3_bad = 0, r4_bad = 0, r11_bad = 0;
    bit done = 0;

    // byte-wide DRAM model
    logic [7:0] mem [0:255];
    logic [3:0] m_row = '0, m_col = '0;
    assign dram_dq_in = mem[{m_row, m_col}];

    always @(negedge dram_ras_n) begin
        if (dram_cas_n) begin
            m_row = dram_addr;
            rowcyc++;
        end else begin
            cbr++;
            if (!dram_we_n) cbr_bad++;
        end
    end

    always @(negedge dram_cas_n) begin
        if (!dram_ras_n) begin
            m_col = dram_addr;
            if (!dram_we_n) mem[{m_row, m_col}] = dram_dq_out;
        end
    end

    // mid-cycle pin monitor
    logic p_ras = 1, p_cas = 1, p_oe = 0, h_pend = 0, h_oe = 0;
    logic [MA-1:0] p_addr = '0, h_addr = '0;
    logic [7:0] p_dq = '0, h_dq = '0;
    int hi_run = 100;
    always @(negedge clk) begin
        if (rst_n) begin
            if (h_pend) begin
                if (dram_addr != h_addr) r4_bad++;
                if (h_oe && dram_dq_out != h_dq) r4_bad++;
                h_pend = 0;
            end
            if (p_cas && !dram_cas_n && !dram_ras_n) begin
                if (dram_addr != p_addr) r4_bad++;
                if (dram_dq_oe && dram_dq_out != p_dq) r4_bad++;
                h_pend = 1; h_addr = dram_addr; h_oe = dram_dq_oe; h_dq = dram_dq_out;
            end
            if (p_ras && !dram_ras_n && dram_cas_n && dram_addr != p_addr) r3_bad++;
            if (dram_ras_n) hi_run++;
            else begin
                if (p_ras && hi_run < TRP) r11_bad++;
                hi_run = 0;
            end
        end
        p_ras = dram_ras_n; p_cas = dram_cas_n; p_addr = dram_addr;
        p_dq = dram_dq_out; p_oe = dram_dq_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mword(input int a);
        return {mem[2*a+1], mem[2*a]};
    endfunction

    task automatic cpu_read(input int a, output logic [15:0] d, output int lat);
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = a[AW-1:0]; lat = 0;
        do begin @(negedge clk); lat++; end while (!cpu_ack && lat < 500);
        if (!cpu_ack) chk(0, "R2 read timeout", lat, 0);
        d = cpu_rdata; cpu_req = 0;
    endtask

    task automatic cpu_write(input int a, input logic [15:0] w, output int lat);
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = a[AW-1:0]; cpu_wdata = w; lat = 0;
        do begin @(negedge clk); lat++; end while (!cpu_ack && lat < 500);
        if (!cpu_ack) chk(0, "R6 write timeout", lat, 0);
        cpu_req = 0; cpu_we = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes in reset",
            {dram_ras_n, dram_cas_n, dram_we_n}, 7);
        chk(!dram_dq_oe && !cpu_ack, "R1 oe/ack in reset", {dram_dq_oe, cpu_ack}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && !cpu_ack, "R1 after reset",
            {dram_ras_n, dram_cas_n, cpu_ack}, 6);
    endtask

    task automatic t_read_miss(input int a);
        logic [15:0] d; int lat, rc;
        rc = rowcyc;
        cpu_read(a, d, lat);
        chk(d == mword(a), "R2 miss data", d, mword(a));
        chk(lat > 2 && rowcyc == rc + 1, "R2 wait states / one row cycle", lat, rowcyc - rc);
        @(negedge clk);
        chk(!cpu_ack, "R2 ack single pulse", cpu_ack, 0);
        idle(30);
    endtask

    task automatic t_prefetch_hit(input int a);
        logic [15:0] d; int lat, rc;
        t_read_miss(a);
        rc = rowcyc;
        cpu_read((a + 1) % 128, d, lat);
        chk(d == mword((a + 1) % 128), "R7 hit data", d, mword((a + 1) % 128));
        chk(lat <= 2 && rowcyc == rc, "R7 hit without row cycle", lat, rowcyc - rc);
        idle(30);
    endtask

    task automatic t_posted_write;
        int l1, l2;
        cpu_write(20, 16'h1234, l1);
        chk(l1 <= 2, "R6 posted ack latency", l1, 2);
        cpu_write(21, 16'hBEEF, l2);
        chk(l2 > 2, "R6 second write stalls on drain", l2, 3);
        idle(40);
        chk(mem[40] == 8'h34 && mem[41] == 8'h12, "R5 byte split word 20",
            {mem[41], mem[40]}, 16'h1234);
        chk(mword(21) == 16'hBEEF, "R5 byte split word 21", mword(21), 16'hBEEF);
    endtask

    task automatic t_raw;
        logic [15:0] d; int l;
        cpu_write(30, 16'hA55A, l);
        cpu_read(30, d, l);
        chk(d == 16'hA55A, "R9 read after posted write", d, 16'hA55A);
        cpu_write(50, 16'h0F0F, l);
        cpu_read(60, d, l);
        chk(d == mword(60), "R9 read other address behind write", d, mword(60));
        idle(30);
    endtask

    task automatic t_invalidate;
        logic [15:0] d; int l;
        t_read_miss(40);
        cpu_write(41, 16'h7E57, l);
        idle(40);
        cpu_read(41, d, l);
        chk(d == 16'h7E57, "R8 stale prefetch dropped", d, 16'h7E57);
        idle(30);
    endtask

    task automatic t_refresh;
        int c0;
        c0 = cbr;
        idle(2 * REF + 50);
        chk(cbr - c0 >= 2, "R10 refresh count", cbr - c0, 2);
        chk(cbr_bad == 0, "R10 refresh with WE high", cbr_bad, 0);
    endtask

    task automatic t_timing;
        chk(r3_bad == 0, "R3 row address setup/hold", r3_bad, 0);
        chk(r4_bad == 0, "R4 column/data setup/hold", r4_bad, 0);
        chk(r11_bad == 0, "R11 precharge gap", r11_bad, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        t_reset();
        t_read_miss(5);
        t_read_miss(77);
        t_prefetch_hit(9);
        t_prefetch_hit(127);
        t_posted_write();
        t_raw();
        t_invalidate();
        t_refresh();
        t_timing();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule